// File: doc/BRIEF.md
# Watchdog Timer with Keyed Arm and Disarm

This block is a register-mapped watchdog. Software programs a reload value and a reset-pulse length. It then arms the countdown by writing one fixed pair of keys to the control register. A different pair of keys stops the watchdog and restores the count. The count falls by one on every cycle in which the reference tick input is high. When the count runs out, the block latches an expiry flag and drives its interrupt. It also asserts a reset output for the programmed number of reference ticks. The block also accepts a software reset request. It keeps a sticky record of every reset cause it has seen.

The register port is a plain single-cycle bus. A write takes effect on the clock edge where `wr_en` is high. `rdata` follows `addr` combinationally. There is no streamed data path, so the bus has no valid/ready handshake and no back-pressure. The reference tick is an enable pulse, one cycle long, that is synchronous to `clk`.

Top module: `wdt_keyed_top`

## Requirements
- R1: After power-on reset (`rst_n` low), the reset-cause register (offset 0x38) reads 0x8000_0000, the control register (0x2C) reads 0, and `irq`, `wdt_rst_out` and `soft_rst_out` are low.
- R2: A write of 0x0000_FF00 to 0x2C, followed by a write of 0x0000_00FF to 0x2C, loads the count from the default-count register (0x28) and starts the countdown. Idle bus cycles between the two writes are allowed. After that, each `ref_tick` lowers the count by one.
- R3: A write of 0x0000_EE00 to 0x2C, followed by a write of 0x0000_00EE to 0x2C, stops the countdown and reloads the count from the default-count register.
- R4: A key sequence is cancelled by any write that comes between its two keys. This covers a write of any other value to 0x2C and a write to any other offset. The cancelled sequence does not change whether the watchdog is running or stopped, and it does not change the count.
- R5: A read of 0x2C returns the current count, zero-extended to 32 bits.
- R6: With default value D, expiry occurs on the max(D,1)-th tick after the start. At expiry, bit 4 of the status register (0x24) and `irq` go high, the count reads 0, and the countdown stops.
- R7: At expiry, `wdt_rst_out` rises in the same cycle as the expiry flag. It stays high for max(L,1) reference ticks, where L is the value in the pulse-length register (0x30).
- R8: Writing 1 to bit 4 of 0x24 clears the expiry flag and `irq`. Bits 0 to 3 of 0x24 always read 0.
- R9: A write to 0x28 does not change the count. The new value takes effect only at the next start or stop.
- R10: A write to 0x34 with bit 0 set makes `soft_rst_out` high for one cycle and sets reset-cause bit 29. A write with bit 0 clear has no effect. The register 0x34 reads 0.
- R11: The reset-cause bits are:
  - bit 31: power-on reset;
  - bit 30: watchdog expiry or `hw_rst_evt`;
  - bit 29: software reset;
  - bit 28: `pcie_rst_evt`.

  These bits are sticky. Only power-on reset clears them, bus writes to 0x38 are ignored, and all other bits read 0.
- R12: A start sequence issued while the watchdog is running reloads the count from the default-count register, and the countdown continues.
- R13: While `ref_tick` is low, neither the count nor the length of the reset pulse advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low |
| ref_tick | input | 1 | Reference tick enable, one cycle per tick |
| hw_rst_evt | input | 1 | Pulse that records a hardware reset cause |
| pcie_rst_evt | input | 1 | Pulse that records a PCIe reset cause |
| addr | input | ADDR_W | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Watchdog expiry flag |
| wdt_rst_out | output | 1 | Watchdog reset pulse |
| soft_rst_out | output | 1 | Software reset request, one cycle |

## Verification
The assertions check the following on every cycle:
- the countdown lowers the count by exactly one per tick;
- the count and the pulse counter hold while no tick arrives;
- the watchdog stops at zero after expiry;
- the reset pulse starts on expiry;
- the cause bits never drop;
- a write to a foreign register resets the key tracker;
- the expiry flag clears on a write-1.

Only the bench scenarios can show end-to-end timing: the exact expiry tick and the pulse width for each pair of default and length values. The scenarios also show that broken key sequences leave the running state alone, that the deferred effect of the default register holds, and that the read-back values are correct.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] OFF_ISTAT = 8'h24;
  localparam logic [7:0] OFF_DEF   = 8'h28;
  localparam logic [7:0] OFF_CTRL  = 8'h2C;
  localparam logic [7:0] OFF_PLEN  = 8'h30;
  localparam logic [7:0] OFF_SRST  = 8'h34;
  localparam logic [7:0] OFF_CAUSE = 8'h38;

  localparam logic [31:0] KEY_ARM_A = 32'h0000_FF00;
  localparam logic [31:0] KEY_ARM_B = 32'h0000_00FF;
  localparam logic [31:0] KEY_DIS_A = 32'h0000_EE00;
  localparam logic [31:0] KEY_DIS_B = 32'h0000_00EE;

  localparam int EXP_BIT = 4;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ARM, SEQ_DIS} seq_e;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        any_wr,
  input  logic        ctrl_wr,
  input  logic [31:0] wdata,
  output logic        arm,
  output logic        disarm
);
  seq_e seq_q, seq_d;

  always_comb begin
    arm    = ctrl_wr && (seq_q == SEQ_ARM) && (wdata == KEY_ARM_B);
    disarm = ctrl_wr && (seq_q == SEQ_DIS) && (wdata == KEY_DIS_B);
    seq_d  = seq_q;
    if (any_wr) begin
      if (!ctrl_wr || arm || disarm) seq_d = SEQ_IDLE;
      else if (wdata == KEY_ARM_A)   seq_d = SEQ_ARM;
      else if (wdata == KEY_DIS_A)   seq_d = SEQ_DIS;
      else                           seq_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_q <= SEQ_IDLE;
    else        seq_q <= seq_d;
  end

  // R4
  foreign_wr_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && !ctrl_wr) |=> (seq_q == SEQ_IDLE));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             arm,
  input  logic             disarm,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = running && tick && (count <= ONE) && !arm && !disarm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else if (arm) begin
      count   <= load_val;
      running <= 1'b1;
    end else if (disarm) begin
      count   <= load_val;
      running <= 1'b0;
    end else if (expire) begin
      count   <= '0;
      running <= 1'b0;
    end else if (running && tick) begin
      count   <= count - ONE;
    end
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && count > ONE && !arm && !disarm) |=> (count == $past(count) - ONE));
  // R13
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !arm && !disarm) |=> ($stable(count) && $stable(running)));
  // R6
  expire_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!running && count == '0));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PLS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             fire,
  input  logic [PLS_W-1:0] len,
  output logic             active
);
  logic [PLS_W-1:0] cnt_q;

  assign active = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (fire)             cnt_q <= (len == '0) ? PLS_W'(1) : len;
    else if (tick && active)   cnt_q <= cnt_q - PLS_W'(1);
  end

  // R7
  pulse_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> active);
  // R13
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !fire) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int PLS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              hw_rst_evt,
  input  logic              pcie_rst_evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic              wdt_rst_out,
  output logic              soft_rst_out
);
  localparam int CAUSE_W = 4;
  localparam int CAUSE_LSB = 32 - CAUSE_W;

  logic [CNT_W-1:0]   def_q;
  logic [PLS_W-1:0]   plen_q;
  logic               flag_q;
  logic               soft_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [CNT_W-1:0]   count;
  logic               running;
  logic               expire;
  logic               arm, disarm;
  logic               ctrl_wr, istat_wr, def_wr, plen_wr, srst_wr;
  logic               soft_req;

  assign ctrl_wr  = wr_en && (addr == ADDR_W'(OFF_CTRL));
  assign istat_wr = wr_en && (addr == ADDR_W'(OFF_ISTAT));
  assign def_wr   = wr_en && (addr == ADDR_W'(OFF_DEF));
  assign plen_wr  = wr_en && (addr == ADDR_W'(OFF_PLEN));
  assign srst_wr  = wr_en && (addr == ADDR_W'(OFF_SRST));
  assign soft_req = srst_wr && wdata[0];

  wdt_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .any_wr(wr_en), .ctrl_wr(ctrl_wr),
    .wdata(wdata), .arm(arm), .disarm(disarm)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .arm(arm), .disarm(disarm),
    .load_val(def_q), .count(count), .running(running), .expire(expire)
  );

  wdt_pulse #(.PLS_W(PLS_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .fire(expire),
    .len(plen_q), .active(wdt_rst_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      def_q   <= '0;
      plen_q  <= '0;
      flag_q  <= 1'b0;
      soft_q  <= 1'b0;
      cause_q <= 4'b1000;
    end else begin
      if (def_wr)  def_q  <= wdata[CNT_W-1:0];
      if (plen_wr) plen_q <= wdata[PLS_W-1:0];
      if (expire)                         flag_q <= 1'b1;
      else if (istat_wr && wdata[EXP_BIT]) flag_q <= 1'b0;
      soft_q  <= soft_req;
      cause_q <= cause_q | {1'b0, expire | hw_rst_evt, soft_req, pcie_rst_evt};
    end
  end

  assign irq          = flag_q;
  assign soft_rst_out = soft_q;

  always_comb begin
    rdata = '0;
    if      (addr == ADDR_W'(OFF_CTRL))  rdata = 32'(count);
    else if (addr == ADDR_W'(OFF_ISTAT)) rdata[EXP_BIT] = flag_q;
    else if (addr == ADDR_W'(OFF_DEF))   rdata = 32'(def_q);
    else if (addr == ADDR_W'(OFF_PLEN))  rdata = 32'(plen_q);
    else if (addr == ADDR_W'(OFF_CAUSE)) rdata[31:CAUSE_LSB] = cause_q;
  end

  // R11
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q & $past(cause_q)) == $past(cause_q)));
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (istat_wr && wdata[EXP_BIT] && !expire) |=> !irq);
  // R10
  sw_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_out |-> cause_q[1]);
  // R6
  expire_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (irq && wdt_rst_out));
endmodule

// File: tb/tb_wdt_keyed_top.sv
module tb_wdt_keyed_top;
  localparam int CLK_P = 10;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b1;
  logic hw_rst_evt = 1'b0;
  logic pcie_rst_evt = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, wdt_rst_out, soft_rst_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic last_soft;

  wdt_keyed_top #(.ADDR_W(AW), .CNT_W(16), .PLS_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .hw_rst_evt(hw_rst_evt),
    .pcie_rst_evt(pcie_rst_evt), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq(irq), .wdt_rst_out(wdt_rst_out), .soft_rst_out(soft_rst_out)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    last_soft = soft_rst_out;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    int n, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h38, v); chk("R1 cause", v, 32'h8000_0000);
    rd(8'h2C, v); chk("R1 count", v, 0);
    chk("R1 outs", {29'd0, irq, wdt_rst_out, soft_rst_out}, 0);

    // R11 external causes, sticky, write ignored
    hw_rst_evt = 1'b1; @(negedge clk); hw_rst_evt = 1'b0;
    rd(8'h38, v); chk("R11 hw", v, 32'hC000_0000);
    pcie_rst_evt = 1'b1; @(negedge clk); pcie_rst_evt = 1'b0;
    rd(8'h38, v); chk("R11 pcie", v, 32'hD000_0000);
    wr(8'h38, 32'h0);
    rd(8'h38, v); chk("R11 write ignored", v, 32'hD000_0000);

    // R10 soft reset
    wr(8'h34, 32'h2);
    chk("R10 no pulse", {31'd0, last_soft}, 0);
    rd(8'h38, v); chk("R10 no cause", v, 32'hD000_0000);
    wr(8'h34, 32'h1);
    chk("R10 pulse", {31'd0, last_soft}, 1);
    @(negedge clk);
    chk("R10 one cycle", {31'd0, soft_rst_out}, 0);
    rd(8'h38, v); chk("R10 cause", v, 32'hF000_0000);
    rd(8'h34, v); chk("R10 read zero", v, 0);

    // R9 default write does not touch count
    wr(8'h28, 32'd5);
    rd(8'h2C, v); chk("R9 count untouched", v, 0);

    // R2 R5 R6 R7 R8 sweep over default and pulse length
    for (int d = 0; d <= 6; d++) begin
      for (int l = 0; l <= 4; l++) begin
        wr(8'h28, d); wr(8'h30, l);
        wr(8'h2C, 32'hFF00); wr(8'h2C, 32'hFF);
        rd(8'h2C, v); chk("R2 load", v, d);
        n = 0;
        while (!wdt_rst_out && n < 50) begin
          @(negedge clk); n++;
          if (!wdt_rst_out) begin rd(8'h2C, v); chk("R5 count", v, d - n); end
        end
        chk("R6 expiry tick", n, (d == 0) ? 1 : d);
        chk("R6 irq", {31'd0, irq}, 1);
        rd(8'h2C, v); chk("R6 count zero", v, 0);
        w = 0;
        while (wdt_rst_out && w < 50) begin @(negedge clk); w++; end
        chk("R7 width", w, (l == 0) ? 1 : l);
        rd(8'h2C, v); chk("R6 stopped", v, 0);
        rd(8'h24, v); chk("R8 status", v, 32'h10);
        wr(8'h24, 32'h0F);
        chk("R8 no clear", {31'd0, irq}, 1);
        wr(8'h24, 32'h10);
        chk("R8 clear", {31'd0, irq}, 0);
      end
    end

    // R3 stop and reload
    wr(8'h28, 32'd20);
    wr(8'h2C, 32'hFF00); wr(8'h2C, 32'hFF);
    repeat (5) @(negedge clk);
    wr(8'h2C, 32'hEE00); wr(8'h2C, 32'hEE);
    rd(8'h2C, v); chk("R3 reload", v, 20);
    repeat (3) @(negedge clk);
    rd(8'h2C, v); chk("R3 stopped", v, 20);

    // R9 takes effect only at next stop/start
    wr(8'h28, 32'd9);
    rd(8'h2C, v); chk("R9 deferred", v, 20);
    wr(8'h2C, 32'hEE00); wr(8'h2C, 32'hEE);
    rd(8'h2C, v); chk("R9 applied", v, 9);

    // R4 broken sequences while stopped
    wr(8'h2C, 32'hFF00); wr(8'h2C, 32'h1234); wr(8'h2C, 32'hFF);
    @(negedge clk); rd(8'h2C, v); chk("R4 bad value", v, 9);
    wr(8'h2C, 32'hFF00); wr(8'h30, 32'd1); wr(8'h2C, 32'hFF);
    @(negedge clk); rd(8'h2C, v); chk("R4 foreign write", v, 9);
    wr(8'h2C, 32'hFF);
    @(negedge clk); rd(8'h2C, v); chk("R4 lone key", v, 9);

    // R12 restart while running
    wr(8'h2C, 32'hFF00); wr(8'h2C, 32'hFF);
    repeat (4) @(negedge clk);
    wr(8'h2C, 32'hFF00); wr(8'h2C, 32'hFF);
    rd(8'h2C, v); chk("R12 kick reload", v, 9);

    // R4 broken stop while running keeps running
    wr(8'h2C, 32'hEE00); wr(8'h2C, 32'h0); wr(8'h2C, 32'hEE);
    rd(8'h2C, v); @(negedge clk); rd(8'h2C, v2);
    chk("R4 still running", v - v2, 1);
    wr(8'h2C, 32'hEE00); wr(8'h2C, 32'hEE);

    // R13 no tick holds count and pulse
    ref_tick = 1'b0;
    wr(8'h2C, 32'hFF00); wr(8'h2C, 32'hFF);
    repeat (5) @(negedge clk);
    rd(8'h2C, v); chk("R13 count hold", v, 9);
    ref_tick = 1'b1;
    @(negedge clk); rd(8'h2C, v); chk("R13 resume", v, 8);
    wr(8'h30, 32'd2);
    n = 0;
    while (!wdt_rst_out && n < 50) begin @(negedge clk); n++; end
    ref_tick = 1'b0;
    repeat (6) @(negedge clk);
    chk("R13 pulse hold", {31'd0, wdt_rst_out}, 1);
    ref_tick = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 pulse ends", {31'd0, wdt_rst_out}, 0);

    finish_run();
  end
endmodule